// File: doc/BRIEF.md
# Message-Signalled Interrupt Address Generator

This block turns interrupt forwarding requests into memory writes. It holds two sets of message address configuration (one for the machine level, one for the supervisor level). Each set has a low word and a high word, and a lock flag in the machine high word freezes both sets. For every message it splits a 14-bit hart index into a group part and an in-group part, using programmable widths and shifts. It packs those parts together with a guest index into a page number on top of a base page, and then issues one 32-bit data write. The write carries the 11-bit external interrupt identity to the 64-bit byte address formed from that page number.

Requests come from two places. The first is a table of per-source target words: a source is forwarded once the domain enable is set and the source is both enabled and pending. The second is a software generate register, whose write sends exactly one message. Messages leave through a single valid/ready write channel. Sources that qualify are served lowest index first. A source's pending bit clears only when its message is accepted.

A parameter selects the level the instance serves. A machine-level instance uses the machine configuration and always sends guest index 0. A supervisor-level instance uses the supervisor configuration and sends the guest index stored in the target word.

Top module: `msi_addr_gen`

## Requirements
- R1: Configuration select encoding is 0 = machine low, 1 = machine high, 2 = supervisor low, 3 = supervisor high. A low word stores all 32 bits. A high word stores only bit 31, bits 28:24, 22:20, 18:16, 15:12 and 11:0, which means a write is masked with 0x9F77FFFF.
- R2: Once bit 31 of the machine high word is set, writes to all four configuration words are ignored until reset.
- R3: With HAS_CHILD = 0 the two supervisor words read as 0 and ignore writes.
- R4: Let the high word carry in-group width W = bits 15:12, group width V = bits 18:16, in-group shift S = bits 22:20, group shift T = bits 28:24 and base page bits 11:0, with the low word holding base page bits 31:0. Then page = {hi[11:0], lo} | ((hart >> W) & (2^V−1)) << (T+12) | (hart & (2^W−1)) << S | (guest & (2^S−1)), and msg_addr = page << 12, truncated to 64 bits.
- R5: msg_data is the 11-bit interrupt identity in bits 10:0 with bits 31:11 zero.
- R6: A target word holds the hart index in bits 31:18, the guest index in bits 17:12 and the identity in bits 10:0. A machine-level instance (MACHINE_LEVEL = 1) uses the machine words and guest index 0. A supervisor-level instance uses the supervisor words and the stored guest index.
- R7: A source produces a message only while domain_en, its src_en bit and its pending bit are all 1. Otherwise no message is sent and the pending bit is kept.
- R8: A waiting generate request is sent before any source. Among qualifying sources the lowest index is sent first.
- R9: A src_set pulse sets the pending bit. The bit clears only in the cycle its message is accepted, and a set in that same cycle wins.
- R10: While msg_valid is 1 and msg_ready is 0, msg_valid, msg_addr and msg_data hold.
- R11: A generate write stores the value with bits 17:12 cleared, which gen_rdata returns. It then sends one message with hart = bits 31:18, guest 0 and identity = bits 10:0, whatever domain_en is. A second write before the first is selected replaces it.
- R12: After reset msg_valid, src_pend, gen_rdata and all configuration words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_waddr | input | 2 | Configuration word written |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_raddr | input | 2 | Configuration word read |
| cfg_rdata | output | 32 | Configuration read value |
| domain_en | input | 1 | Domain-wide forwarding enable |
| tgt_we | input | 1 | Target word write strobe |
| tgt_idx | input | IDX_W | Source whose target word is written |
| tgt_wdata | input | 32 | Target word value |
| src_en | input | N_SRC | Per-source enable |
| src_set | input | N_SRC | Per-source pending set pulse |
| src_pend | output | N_SRC | Per-source pending bits |
| gen_we | input | 1 | Generate register write strobe |
| gen_wdata | input | 32 | Generate register value |
| gen_rdata | output | 32 | Stored generate register |
| msg_valid | output | 1 | Write request valid |
| msg_ready | input | 1 | Write request accepted |
| msg_addr | output | 64 | Write byte address |
| msg_data | output | 32 | Write data word |

## Verification
The bench builds two instances, each with four sources. The first is a supervisor-level instance with a child domain; it exercises the supervisor configuration words, the stored guest index and the guest mask set by the in-group shift. The second is a machine-level instance without a child; it shows the guest index forced to zero and the absent supervisor words. On the first instance, several shift and width settings and a stalled channel expose the priority between the generate register and the sources, and the moment pending bits clear.

// File: rtl/msi_fwd_pkg.sv
// Shared field positions, masks and types for the message address generator.
package msi_fwd_pkg;
    localparam int HART_W    = 14;
    localparam int GUEST_W   = 6;
    localparam int IID_W     = 11;
    localparam int HART_LSB  = 18;
    localparam int GUEST_LSB = 12;
    localparam int LOCK_BIT  = 31;
    localparam logic [31:0] CFG_HI_MASK = 32'h9F77_FFFF;
    localparam logic [31:0] GUEST_FIELD = 32'h0003_F000;

    typedef enum logic [1:0] {
        SEL_M_LO = 2'd0,
        SEL_M_HI = 2'd1,
        SEL_S_LO = 2'd2,
        SEL_S_HI = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [HART_W-1:0]  hart;
        logic [GUEST_W-1:0] guest;
        logic [IID_W-1:0]   iid;
    } fwd_tgt_t;
endpackage

// File: rtl/msi_cfg_regs.sv
// Configuration word file: machine and supervisor low/high address words.
// Assumes one write per cycle; the machine high lock bit freezes all words.
// Supervisor words exist only when HAS_CHILD is set, else they read as zero.
module msi_cfg_regs
    import msi_fwd_pkg::*;
#(
    parameter bit HAS_CHILD = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [1:0]  waddr,
    input  logic [31:0] wdata,
    input  logic [1:0]  raddr,
    output logic [31:0] rdata,
    output logic [31:0] m_lo,
    output logic [31:0] m_hi,
    output logic [31:0] s_lo,
    output logic [31:0] s_hi
);
    logic [31:0] m_lo_q, m_hi_q;
    logic        locked;

    assign locked = m_hi_q[LOCK_BIT];

    // Machine words: written while unlocked, high word masked to its fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_lo_q <= '0;
            m_hi_q <= '0;
        end else if (we && !locked) begin
            if (cfg_sel_e'(waddr) == SEL_M_LO) m_lo_q <= wdata;
            if (cfg_sel_e'(waddr) == SEL_M_HI) m_hi_q <= wdata & CFG_HI_MASK;
        end
    end

    generate
        if (HAS_CHILD) begin : g_sup
            logic [31:0] s_lo_q, s_hi_q;
            // Supervisor words: same lock and mask rules as the machine words.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s_lo_q <= '0;
                    s_hi_q <= '0;
                end else if (we && !locked) begin
                    if (cfg_sel_e'(waddr) == SEL_S_LO) s_lo_q <= wdata;
                    if (cfg_sel_e'(waddr) == SEL_S_HI) s_hi_q <= wdata & CFG_HI_MASK;
                end
            end
            assign s_lo = s_lo_q;
            assign s_hi = s_hi_q;
        end else begin : g_nosup
            assign s_lo = '0;
            assign s_hi = '0;
        end
    endgenerate

    assign m_lo = m_lo_q;
    assign m_hi = m_hi_q;

    // Read multiplexer over the four words.
    always_comb begin
        case (cfg_sel_e'(raddr))
            SEL_M_LO: rdata = m_lo;
            SEL_M_HI: rdata = m_hi;
            SEL_S_LO: rdata = s_lo;
            default:  rdata = s_hi;
        endcase
    end
endmodule

// File: rtl/msi_addr_calc.sv
// Combinational address builder: splits the hart index into group and
// in-group parts, packs them with the guest index over the base page and
// returns the byte address. Assumes the configuration high word is already masked.
module msi_addr_calc
    import msi_fwd_pkg::*;
(
    input  logic [31:0]        cfg_lo,
    input  logic [31:0]        cfg_hi,
    input  logic [HART_W-1:0]  hart,
    input  logic [GUEST_W-1:0] guest,
    output logic [63:0]        addr
);
    logic [3:0]  in_w;
    logic [2:0]  grp_w;
    logic [2:0]  in_s;
    logic [4:0]  grp_s;
    logic [63:0] hart64, grp_idx, in_idx, grp_mask, in_mask, guest_mask, page;
    logic        unused_hi;

    assign in_w  = cfg_hi[15:12];
    assign grp_w = cfg_hi[18:16];
    assign in_s  = cfg_hi[22:20];
    assign grp_s = cfg_hi[28:24];
    assign unused_hi = ^{cfg_hi[31:29], cfg_hi[23], cfg_hi[19]};

    // Field split and packing of the page number.
    always_comb begin
        hart64     = {{(64-HART_W){1'b0}}, hart};
        in_mask    = (64'd1 << in_w) - 64'd1;
        grp_mask   = (64'd1 << grp_w) - 64'd1;
        guest_mask = (64'd1 << in_s) - 64'd1;
        grp_idx    = hart64 >> in_w;
        in_idx     = hart64 & in_mask;
        page       = {20'd0, cfg_hi[11:0], cfg_lo};
        page       = page | ((grp_idx & grp_mask) << ({1'b0, grp_s} + 6'd12));
        page       = page | (in_idx << in_s);
        page       = page | ({{(64-GUEST_W){1'b0}}, guest} & guest_mask);
        addr       = page << 12;
    end
endmodule

// File: rtl/msi_src_sched.sv
// Per-source pending bits, target table and lowest-index ready picker.
// Assumes the clear request names the source whose message was accepted.
module msi_src_sched
    import msi_fwd_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             domain_en,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] src_set,
    input  logic             tgt_we,
    input  logic [IDX_W-1:0] tgt_idx,
    input  logic [31:0]      tgt_wdata,
    input  logic             clr_valid,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [N_SRC-1:0] pend,
    output logic             pick_valid,
    output logic [IDX_W-1:0] pick_idx,
    output fwd_tgt_t         pick_tgt
);
    fwd_tgt_t         tgt_q [N_SRC];
    logic [N_SRC-1:0] ready;
    logic             unused_tgt_bit;

    assign unused_tgt_bit = tgt_wdata[11];

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            // Pending bit: set pulse wins over the acceptance clear.
            always_ff @(posedge clk) begin
                if (!rst_n)                                      pend[i] <= 1'b0;
                else if (src_set[i])                             pend[i] <= 1'b1;
                else if (clr_valid && clr_idx == IDX_W'(i))      pend[i] <= 1'b0;
            end
            // Target word: keeps hart, guest and identity fields only.
            always_ff @(posedge clk) begin
                if (!rst_n) tgt_q[i] <= '0;
                else if (tgt_we && tgt_idx == IDX_W'(i)) begin
                    tgt_q[i].hart  <= tgt_wdata[HART_LSB +: HART_W];
                    tgt_q[i].guest <= tgt_wdata[GUEST_LSB +: GUEST_W];
                    tgt_q[i].iid   <= tgt_wdata[IID_W-1:0];
                end
            end
        end
    endgenerate

    assign ready = pend & src_en & {N_SRC{domain_en}};

    // Lowest ready index wins.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (ready[i]) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(i);
            end
        end
        pick_tgt = tgt_q[pick_idx];
    end
endmodule

// File: rtl/msi_addr_gen.sv
// Message-signalled interrupt address generator top. Picks the next message
// (generate register first, then lowest ready source), builds its address
// with the configuration of this instance's level and holds it on a
// valid/ready write channel until accepted. Assumes msg_ready may stall freely.
module msi_addr_gen
    import msi_fwd_pkg::*;
#(
    parameter int N_SRC         = 8,
    parameter bit MACHINE_LEVEL = 1'b1,
    parameter bit HAS_CHILD     = 1'b1,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_waddr,
    input  logic [31:0]      cfg_wdata,
    input  logic [1:0]       cfg_raddr,
    output logic [31:0]      cfg_rdata,
    input  logic             domain_en,
    input  logic             tgt_we,
    input  logic [IDX_W-1:0] tgt_idx,
    input  logic [31:0]      tgt_wdata,
    input  logic [N_SRC-1:0] src_en,
    input  logic [N_SRC-1:0] src_set,
    output logic [N_SRC-1:0] src_pend,
    input  logic             gen_we,
    input  logic [31:0]      gen_wdata,
    output logic [31:0]      gen_rdata,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [63:0]      msg_addr,
    output logic [31:0]      msg_data
);
    logic [31:0] cfg_m_lo, cfg_m_hi, cfg_s_lo, cfg_s_hi, cur_lo, cur_hi;
    logic [31:0] gen_q;
    logic        gen_req_q;
    logic        pick_valid;
    logic [IDX_W-1:0] pick_idx;
    fwd_tgt_t    pick_tgt;
    logic        msg_valid_q, fly_gen_q;
    logic [IDX_W-1:0] fly_idx_q;
    logic [63:0] msg_addr_q, calc_addr;
    logic [31:0] msg_data_q;
    logic        accept, load, use_gen;
    logic [HART_W-1:0]  sel_hart;
    logic [GUEST_W-1:0] sel_guest;
    logic [IID_W-1:0]   sel_iid;
    logic        unused_gen;

    assign unused_gen = ^gen_q[17:11];

    msi_cfg_regs #(.HAS_CHILD(HAS_CHILD)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (cfg_waddr),
        .wdata (cfg_wdata),
        .raddr (cfg_raddr),
        .rdata (cfg_rdata),
        .m_lo  (cfg_m_lo),
        .m_hi  (cfg_m_hi),
        .s_lo  (cfg_s_lo),
        .s_hi  (cfg_s_hi)
    );

    msi_src_sched #(.N_SRC(N_SRC)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .domain_en  (domain_en),
        .src_en     (src_en),
        .src_set    (src_set),
        .tgt_we     (tgt_we),
        .tgt_idx    (tgt_idx),
        .tgt_wdata  (tgt_wdata),
        .clr_valid  (accept && !fly_gen_q),
        .clr_idx    (fly_idx_q),
        .pend       (src_pend),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx),
        .pick_tgt   (pick_tgt)
    );

    // Level picks the configuration set used for every message.
    assign cur_lo = MACHINE_LEVEL ? cfg_m_lo : cfg_s_lo;
    assign cur_hi = MACHINE_LEVEL ? cfg_m_hi : cfg_s_hi;

    assign accept  = msg_valid_q && msg_ready;
    assign use_gen = gen_req_q;
    assign load    = !msg_valid_q && (gen_req_q || pick_valid);

    // Field selection for the next message.
    always_comb begin
        if (use_gen) begin
            sel_hart  = gen_q[HART_LSB +: HART_W];
            sel_guest = '0;
            sel_iid   = gen_q[IID_W-1:0];
        end else begin
            sel_hart  = pick_tgt.hart;
            sel_guest = MACHINE_LEVEL ? '0 : pick_tgt.guest;
            sel_iid   = pick_tgt.iid;
        end
    end

    msi_addr_calc u_calc (
        .cfg_lo (cur_lo),
        .cfg_hi (cur_hi),
        .hart   (sel_hart),
        .guest  (sel_guest),
        .addr   (calc_addr)
    );

    // Generate register and its request-awaiting-selection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q     <= '0;
            gen_req_q <= 1'b0;
        end else if (gen_we) begin
            gen_q     <= gen_wdata & ~GUEST_FIELD;
            gen_req_q <= 1'b1;
        end else if (load && use_gen) begin
            gen_req_q <= 1'b0;
        end
    end

    // Output holding register of the write channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid_q <= 1'b0;
            msg_addr_q  <= '0;
            msg_data_q  <= '0;
            fly_gen_q   <= 1'b0;
            fly_idx_q   <= '0;
        end else if (accept) begin
            msg_valid_q <= 1'b0;
        end else if (load) begin
            msg_valid_q <= 1'b1;
            msg_addr_q  <= calc_addr;
            msg_data_q  <= {{(32-IID_W){1'b0}}, sel_iid};
            fly_gen_q   <= use_gen;
            fly_idx_q   <= pick_idx;
        end
    end

    assign msg_valid = msg_valid_q;
    assign msg_addr  = msg_addr_q;
    assign msg_data  = msg_data_q;
    assign gen_rdata = gen_q;
endmodule

// File: rtl/msi_addr_gen_chk.sv
// Assertion checker for msi_addr_gen, attached by bind below.
module msi_addr_gen_chk #(
    parameter int N_SRC = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             msg_valid,
    input logic             msg_ready,
    input logic [63:0]      msg_addr,
    input logic [31:0]      msg_data,
    input logic [N_SRC-1:0] src_pend,
    input logic [N_SRC-1:0] src_en,
    input logic             domain_en,
    input logic             gen_we,
    input logic             gen_busy,
    input logic [31:0]      cfg_m_lo,
    input logic [31:0]      cfg_m_hi,
    input logic [31:0]      cfg_s_lo,
    input logic [31:0]      cfg_s_hi
);
    // R10: a stalled message holds.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R9: pending bits fall only after an acceptance.
    a_r9_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(msg_valid && msg_ready) |=> (($past(src_pend) & ~src_pend) == '0));

    // R7: nothing to send means nothing appears.
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!msg_valid && !gen_we && !gen_busy && (!domain_en || (src_pend & src_en) == '0))
        |=> !msg_valid);

    // R2: a locked configuration is frozen.
    a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_m_hi[31] |=> $stable({cfg_m_lo, cfg_m_hi, cfg_s_lo, cfg_s_hi}));

    // R1: high words carry only their defined fields.
    a_r1_hi_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_m_hi & ~32'h9F77_FFFF) == '0) && ((cfg_s_hi & ~32'h9F77_FFFF) == '0));

    // R5: data carries only the identity field.
    a_r5_data: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_data[31:11] == '0));
endmodule

bind msi_addr_gen msi_addr_gen_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .src_pend  (src_pend),
    .src_en    (src_en),
    .domain_en (domain_en),
    .gen_we    (gen_we),
    .gen_busy  (gen_req_q),
    .cfg_m_lo  (cfg_m_lo),
    .cfg_m_hi  (cfg_m_hi),
    .cfg_s_lo  (cfg_s_lo),
    .cfg_s_hi  (cfg_s_hi)
);

// File: tb/msi_addr_gen_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks push expected writes, a monitor pops them.
module msi_addr_gen_tb;
    localparam int NS = 4;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // Supervisor-level instance signals.
    logic        cfg_we = 0; logic [1:0] cfg_waddr = 0, cfg_raddr = 0;
    logic [31:0] cfg_wdata = 0, cfg_rdata;
    logic        domain_en = 0, tgt_we = 0; logic [1:0] tgt_idx = 0;
    logic [31:0] tgt_wdata = 0;
    logic [NS-1:0] src_en = 0, src_set = 0, src_pend;
    logic        gen_we = 0; logic [31:0] gen_wdata = 0, gen_rdata;
    logic        msg_valid, msg_ready = 0;
    logic [63:0] msg_addr; logic [31:0] msg_data;

    // Machine-level instance signals.
    logic        m_cfg_we = 0; logic [1:0] m_cfg_waddr = 0, m_cfg_raddr = 0;
    logic [31:0] m_cfg_wdata = 0, m_cfg_rdata;
    logic        m_tgt_we = 0; logic [31:0] m_tgt_wdata = 0;
    logic [NS-1:0] m_src_set = 0, m_src_pend;
    logic [31:0] m_gen_rdata;
    logic        m_valid; logic [63:0] m_addr; logic [31:0] m_data;

    msi_addr_gen #(.N_SRC(NS), .MACHINE_LEVEL(1'b0), .HAS_CHILD(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .domain_en(domain_en), .tgt_we(tgt_we), .tgt_idx(tgt_idx), .tgt_wdata(tgt_wdata),
        .src_en(src_en), .src_set(src_set), .src_pend(src_pend),
        .gen_we(gen_we), .gen_wdata(gen_wdata), .gen_rdata(gen_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

    msi_addr_gen #(.N_SRC(NS), .MACHINE_LEVEL(1'b1), .HAS_CHILD(1'b0)) u_dut_m (
        .clk(clk), .rst_n(rst_n), .cfg_we(m_cfg_we), .cfg_waddr(m_cfg_waddr),
        .cfg_wdata(m_cfg_wdata), .cfg_raddr(m_cfg_raddr), .cfg_rdata(m_cfg_rdata),
        .domain_en(1'b1), .tgt_we(m_tgt_we), .tgt_idx(2'd0), .tgt_wdata(m_tgt_wdata),
        .src_en({NS{1'b1}}), .src_set(m_src_set), .src_pend(m_src_pend),
        .gen_we(1'b0), .gen_wdata(32'd0), .gen_rdata(m_gen_rdata),
        .msg_valid(m_valid), .msg_ready(1'b0), .msg_addr(m_addr), .msg_data(m_data));

    int n_chk = 0, n_bad = 0;
    logic [95:0] exp_q [$];
    logic [31:0] s_lo, s_hi;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Address model written from R4.
    function automatic logic [63:0] exp_addr(input logic [31:0] lo, input logic [31:0] hi,
                                             input int hart, input int guest);
        logic [63:0] h, g, page;
        int w, v, s, t;
        w = int'(hi[15:12]); v = int'(hi[18:16]); s = int'(hi[22:20]); t = int'(hi[28:24]);
        h = 64'(hart); g = 64'(guest);
        page = {20'd0, hi[11:0], lo};
        page = page | (((h >> w) & ((64'd1 << v) - 1)) << (t + 12));
        page = page | ((h & ((64'd1 << w) - 1)) << s);
        page = page | (g & ((64'd1 << s) - 1));
        return page << 12;
    endfunction

    task automatic cyc(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1; cfg_waddr = a; cfg_wdata = d; cyc(); cfg_we = 0;
    endtask

    task automatic cfg_rd(input string req, input logic [1:0] a, input logic [31:0] exp);
        cfg_raddr = a; @(negedge clk); chk(req, cfg_rdata, exp); cyc();
    endtask

    task automatic tgt_wr(input int idx, input int hart, input int guest, input int iid);
        tgt_we = 1; tgt_idx = 2'(idx);
        tgt_wdata = (32'(hart) << 18) | (32'(guest) << 12) | 32'(iid);
        cyc(); tgt_we = 0;
    endtask

    task automatic push(input int hart, input int guest, input int iid);
        exp_q.push_back({exp_addr(s_lo, s_hi, hart, guest), 32'(iid)});
    endtask

    // Monitor: every accepted write is compared against the queue head.
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected message", {msg_data, msg_addr[31:0]}, 64'd0);
            end else begin
                logic [95:0] e;
                e = exp_q.pop_front();
                chk("R4 address", msg_addr, e[95:32]);
                chk("R5 data", {32'd0, msg_data}, {32'd0, e[31:0]});
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] held_a;
        cyc(3); rst_n = 1; cyc();
        // R12: reset state
        @(negedge clk);
        chk("R12 msg_valid", {63'd0, msg_valid}, 64'd0);
        chk("R12 src_pend", {60'd0, src_pend}, 64'd0);
        chk("R12 gen_rdata", {32'd0, gen_rdata}, 64'd0);
        cyc();
        for (int a = 0; a < 4; a++) cfg_rd("R12 config word", 2'(a), 32'd0);

        // R1: masking of high words, low words full
        cfg_wr(2'd3, 32'hFFFF_FFFF); cfg_rd("R1 high mask", 2'd3, 32'h9F77_FFFF);
        cfg_wr(2'd2, 32'h1234_5678); cfg_rd("R1 low word", 2'd2, 32'h1234_5678);
        s_lo = 32'h0008_0000; s_hi = 32'h0432_2001;
        cfg_wr(2'd2, s_lo); cfg_wr(2'd3, s_hi);
        cfg_wr(2'd0, 32'hAAAA_0000); cfg_wr(2'd1, 32'h0000_0005);

        // R4 R5 R6: one source forwarded with its guest index
        tgt_wr(1, 13, 5, 32'h2A);
        domain_en = 1; src_en = 4'hF; msg_ready = 1;
        push(13, 5, 32'h2A);
        src_set = 4'b0010; cyc(); src_set = 0;
        cyc(4);
        chk("R9 pend cleared after accept", {60'd0, src_pend}, 64'd0);
        chk("R6 queue drained", 64'(exp_q.size()), 64'd0);

        // R8: ascending order
        tgt_wr(0, 300, 1, 32'h101); tgt_wr(2, 7, 63, 32'h7FF); tgt_wr(3, 16383, 2, 32'h003);
        push(300, 1, 32'h101); push(7, 63, 32'h7FF); push(16383, 2, 32'h003);
        src_set = 4'b1101; cyc(); src_set = 0;
        cyc(8);
        chk("R8 order drained", 64'(exp_q.size()), 64'd0);

        // R8 R11 R10 R9: generate ahead of a source under a stall
        msg_ready = 0;
        push(9, 0, 32'h155); push(7, 63, 32'h7FF);
        gen_we = 1; gen_wdata = (32'd9 << 18) | (32'h3F << 12) | 32'h155;
        src_set = 4'b0100; cyc(); gen_we = 0; src_set = 0;
        @(negedge clk);
        chk("R11 gen stored guest cleared", {32'd0, gen_rdata}, {32'd0, (32'd9 << 18) | 32'h155});
        cyc(2); @(negedge clk);
        held_a = msg_addr;
        chk("R9 pend kept while stalled", {60'd0, src_pend}, 64'h4);
        chk("R10 valid while stalled", {63'd0, msg_valid}, 64'd1);
        cyc(3); @(negedge clk);
        chk("R10 address held", msg_addr, held_a);
        cyc(); msg_ready = 1; cyc(6);
        chk("R8 gen then source drained", 64'(exp_q.size()), 64'd0);

        // R7: domain disabled, then source disabled
        domain_en = 0; src_set = 4'b0001; cyc(); src_set = 0; cyc(5);
        @(negedge clk);
        chk("R7 no msg with domain off", {63'd0, msg_valid}, 64'd0);
        chk("R7 pend kept domain off", {60'd0, src_pend}, 64'h1);
        cyc(); src_en = 4'hE; domain_en = 1; cyc(5); @(negedge clk);
        chk("R7 no msg with source off", {63'd0, msg_valid}, 64'd0);
        chk("R7 pend kept source off", {60'd0, src_pend}, 64'h1);
        cyc(); push(300, 1, 32'h101); src_en = 4'hF; cyc(5);
        chk("R7 released drained", 64'(exp_q.size()), 64'd0);

        // R11: generate ignores domain enable
        domain_en = 0; push(1, 0, 32'h0AB);
        gen_we = 1; gen_wdata = (32'd1 << 18) | 32'h0AB; cyc(); gen_we = 0; cyc(5);
        chk("R11 gen with domain off drained", 64'(exp_q.size()), 64'd0);
        domain_en = 1;

        // R4: other widths and shifts, guest masked by in-group shift
        s_hi = 32'h0017_00FF; cfg_wr(2'd3, s_hi);
        push(13, 5, 32'h2A);
        src_set = 4'b0010; cyc(); src_set = 0; cyc(5);
        chk("R4 variant drained", 64'(exp_q.size()), 64'd0);

        // R2: lock freezes every word
        cfg_wr(2'd1, 32'h8000_0000);
        cfg_wr(2'd2, 32'hDEAD_BEEF); cfg_wr(2'd0, 32'hFFFF_FFFF); cfg_wr(2'd1, 32'h0);
        cfg_wr(2'd3, 32'h0);
        cfg_rd("R2 S low frozen", 2'd2, s_lo);
        cfg_rd("R2 S high frozen", 2'd3, s_hi);
        cfg_rd("R2 M low frozen", 2'd0, 32'hAAAA_0000);
        cfg_rd("R2 M high frozen", 2'd1, 32'h8000_0000);

        // R3 R6: machine instance without child
        m_cfg_we = 1; m_cfg_waddr = 2'd2; m_cfg_wdata = 32'h1111_1111; cyc();
        m_cfg_waddr = 2'd0; m_cfg_wdata = 32'h0010_0000; cyc();
        m_cfg_waddr = 2'd1; m_cfg_wdata = 32'h0231_3003; cyc(); m_cfg_we = 0;
        m_cfg_raddr = 2'd2; @(negedge clk);
        chk("R3 S low absent", {32'd0, m_cfg_rdata}, 64'd0);
        m_tgt_we = 1; m_tgt_wdata = (32'd2 << 18) | (32'd7 << 12) | 32'h33; cyc(); m_tgt_we = 0;
        m_src_set = 4'b0001; cyc(); m_src_set = 0; cyc(2); @(negedge clk);
        chk("R6 machine valid", {63'd0, m_valid}, 64'd1);
        chk("R6 machine guest zero", m_addr, exp_addr(32'h0010_0000, 32'h0231_3003, 2, 0));
        chk("R5 machine data", {32'd0, m_data}, 64'h33);

        cyc(2);
        chk("R8 scoreboard empty", 64'(exp_q.size()), 64'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule